// File: doc/BRIEF.md
# Address and Stack Fault Detector

This block watches a CPU core's memory traffic and raises a fault pulse when the core does something it must not. It checks three things: each data access, each new program counter value, and each stack pointer update. A data access faults when a word access uses an odd address, or when the address falls outside the implemented data window. A program-flow target faults when it lies above the implemented program memory, or when it lands inside the interrupt vector area. A stack pointer update faults when the pointer exceeds a software-programmed limit, or when it drops below a fixed floor of 0x0800.

The data-side and program-side checks merge into one address-error pulse. The stack checks drive a separate stack-error pulse. Both pulses are registered and go to a trap controller. The block does not stop the access, fetch a vector or run a trap sequence. The address windows and the stack floor are parameters. The stack limit is a register that software loads through a write strobe.

Top module: `mem_fault_guard`

## Requirements
- R1: While `rst_n` is low, both fault outputs are 0 on every clock. The stack limit resets to all ones, so a stack pointer of 0xFFFF raises no stack error after reset.
- R2: A data access with `dacc_vld`=1, `dacc_word`=1 and `dacc_addr[0]`=1 raises `addr_err` on the clock after it is presented.
- R3: A byte access (`dacc_word`=0) is never checked for alignment. An odd address inside the data window raises no fault.
- R4: A data access of either size whose address is below `DATA_LO` or above `DATA_HI` raises `addr_err` one clock later. Both bounds themselves are legal.
- R5: A program target (`pc_vld`=1) above `PROG_HI` raises `addr_err` one clock later. `PROG_HI` itself is legal.
- R6: A program target in the range `VEC_LO` to `VEC_HI` inclusive raises `addr_err` one clock later. `VEC_LO`-1 and `VEC_HI`+1 are legal.
- R7: A stack update (`sp_vld`=1) with a value greater than the current limit raises `stk_err` one clock later. A value equal to the limit is legal.
- R8: A stack update with a value below `SP_FLOOR` (0x0800) raises `stk_err` one clock later. 0x0800 itself is legal.
- R9: An address fault and a stack fault presented in the same cycle are both reported in the same following cycle.
- R10: Each fault pulse lasts exactly one clock for each offending cycle. Address values presented with their strobe low have no effect on the outputs.
- R11: A limit write (`lim_wr`=1) takes effect from the next cycle. A stack update in the same cycle as the write is compared against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dacc_vld | input | 1 | Data access strobe |
| dacc_addr | input | ADDR_W | Data effective address |
| dacc_word | input | 1 | 1 = word (2-byte) access, 0 = byte access |
| pc_vld | input | 1 | Program-flow target strobe (fetch, branch, jump or program counter write) |
| pc_addr | input | PC_W | New program counter value |
| sp_vld | input | 1 | Stack pointer update strobe |
| sp_val | input | ADDR_W | New stack pointer value |
| lim_wr | input | 1 | Stack limit write strobe |
| lim_wdata | input | ADDR_W | Stack limit write value |
| addr_err | output | 1 | Registered address-error pulse |
| stk_err | output | 1 | Registered stack-error pulse |

## Verification
The hardest situation to reach from the ports is a limit write that coincides with a stack update sitting between the old and the new limit. Only the ordering in R11 decides whether that update faults. Uniform random stimulus almost never produces it. The bench therefore has a directed sequence that writes a lower limit while presenting an update just above it, and then repeats the same update on the next cycle. The random phase biases stack values to the floor, the current limit and their neighbours, and issues limit writes often. This lets one-above and one-below cases appear at both bounds, mixed with simultaneous data and program faults.

// File: rtl/fault_guard_pkg.sv
// Shared types for the address/stack fault detector.
// Assumes: consumers only OR the cause bits together.
package fault_guard_pkg;
    typedef struct packed {
        logic misalign;     // word access at odd address
        logic out_of_data;  // address outside the implemented data window
    } data_fault_t;

    typedef struct packed {
        logic beyond_prog;  // target above implemented program memory
        logic in_vector;    // target inside the vector area
    } pc_fault_t;

    typedef struct packed {
        logic over_limit;   // pointer above the programmed limit
        logic under_floor;  // pointer below the fixed floor
    } stack_fault_t;
endpackage

// File: rtl/data_access_chk.sv
// Combinational data access checker: flags odd word addresses and
// addresses outside [DATA_LO, DATA_HI].
// Assumes: DATA_LO <= DATA_HI and both fit in ADDR_W bits.
module data_access_chk
    import fault_guard_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_LO = 32'h0040,
    parameter int unsigned DATA_HI = 32'h27FF
) (
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    output data_fault_t       flt
);
    localparam logic [ADDR_W-1:0] LO = DATA_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI = DATA_HI[ADDR_W-1:0];
    localparam bit HAS_LOW_GAP  = (DATA_LO != 0);
    localparam bit HAS_HIGH_GAP = (DATA_HI < (2 ** ADDR_W) - 1);

    logic below, above;

    // Lower window bound: only built when space exists below the window.
    generate
        if (HAS_LOW_GAP) begin : g_low
            assign below = (addr < LO);
        end else begin : g_nolow
            assign below = 1'b0;
        end
    endgenerate

    // Upper window bound: only built when space exists above the window.
    generate
        if (HAS_HIGH_GAP) begin : g_high
            assign above = (addr > HI);
        end else begin : g_nohigh
            assign above = 1'b0;
        end
    endgenerate

    // Cause bits; byte accesses skip the alignment test.
    always_comb begin
        flt.misalign    = vld & word & addr[0];
        flt.out_of_data = vld & (below | above);
    end
endmodule

// File: rtl/pc_target_chk.sv
// Combinational program-flow target checker: flags targets above
// PROG_HI and targets inside [VEC_LO, VEC_HI].
// Assumes: VEC_LO <= VEC_HI <= PROG_HI.
module pc_target_chk
    import fault_guard_pkg::*;
#(
    parameter int unsigned PC_W    = 24,
    parameter int unsigned PROG_HI = 32'h007FFF,
    parameter int unsigned VEC_LO  = 32'h000004,
    parameter int unsigned VEC_HI  = 32'h00007F
) (
    input  logic            vld,
    input  logic [PC_W-1:0] pc,
    output pc_fault_t       flt
);
    localparam logic [PC_W-1:0] PHI = PROG_HI[PC_W-1:0];
    localparam logic [PC_W-1:0] VLO = VEC_LO[PC_W-1:0];
    localparam logic [PC_W-1:0] VHI = VEC_HI[PC_W-1:0];

    logic vec_lo_ok;

    // Vector lower bound: trivially met when the area starts at zero.
    generate
        if (VEC_LO != 0) begin : g_vlo
            assign vec_lo_ok = (pc >= VLO);
        end else begin : g_vzero
            assign vec_lo_ok = 1'b1;
        end
    endgenerate

    // Cause bits for a presented target.
    always_comb begin
        flt.beyond_prog = vld & (pc > PHI);
        flt.in_vector   = vld & vec_lo_ok & (pc <= VHI);
    end
endmodule

// File: rtl/stack_bound_chk.sv
// Stack pointer bound checker with its software-loaded limit register.
// The limit resets to all ones; a write lands at the clock edge, so
// an update in the same cycle is compared with the old limit.
// Assumes: SP_FLOOR fits in ADDR_W bits and is non-zero.
module stack_bound_chk
    import fault_guard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned SP_FLOOR = 32'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [ADDR_W-1:0] sp,
    input  logic              lim_wr,
    input  logic [ADDR_W-1:0] lim_wdata,
    output stack_fault_t      flt
);
    localparam logic [ADDR_W-1:0] FLOOR = SP_FLOOR[ADDR_W-1:0];

    logic [ADDR_W-1:0] lim_q;

    // Limit register: reset to maximum, load on software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_q <= '1;
        else if (lim_wr) lim_q <= lim_wdata;
    end

    // Two-sided bound comparison against the current limit.
    always_comb begin
        flt.over_limit  = vld & (sp > lim_q);
        flt.under_floor = vld & (sp < FLOOR);
    end
endmodule

// File: rtl/mem_fault_guard.sv
// Top of the address/stack fault detector. Merges the data and program
// checks into one registered address-error pulse and the stack checks
// into a registered stack-error pulse, each one clock after the cause.
// Assumes: strobes are single-cycle qualifiers of their value buses.
module mem_fault_guard
    import fault_guard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PC_W     = 24,
    parameter int unsigned DATA_LO  = 32'h0040,
    parameter int unsigned DATA_HI  = 32'h27FF,
    parameter int unsigned PROG_HI  = 32'h007FFF,
    parameter int unsigned VEC_LO   = 32'h000004,
    parameter int unsigned VEC_HI   = 32'h00007F,
    parameter int unsigned SP_FLOOR = 32'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dacc_vld,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              dacc_word,
    input  logic              pc_vld,
    input  logic [PC_W-1:0]   pc_addr,
    input  logic              sp_vld,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic              lim_wr,
    input  logic [ADDR_W-1:0] lim_wdata,
    output logic              addr_err,
    output logic              stk_err
);
    data_fault_t  d_flt;
    pc_fault_t    p_flt;
    stack_fault_t s_flt;

    data_access_chk #(
        .ADDR_W (ADDR_W),
        .DATA_LO(DATA_LO),
        .DATA_HI(DATA_HI)
    ) u_data (
        .vld (dacc_vld),
        .addr(dacc_addr),
        .word(dacc_word),
        .flt (d_flt)
    );

    pc_target_chk #(
        .PC_W   (PC_W),
        .PROG_HI(PROG_HI),
        .VEC_LO (VEC_LO),
        .VEC_HI (VEC_HI)
    ) u_pc (
        .vld(pc_vld),
        .pc (pc_addr),
        .flt(p_flt)
    );

    stack_bound_chk #(
        .ADDR_W  (ADDR_W),
        .SP_FLOOR(SP_FLOOR)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (sp_vld),
        .sp       (sp_val),
        .lim_wr   (lim_wr),
        .lim_wdata(lim_wdata),
        .flt      (s_flt)
    );

    // Register the merged cause bits into the two trap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_err <= 1'b0;
            stk_err  <= 1'b0;
        end else begin
            addr_err <= (|d_flt) | (|p_flt);
            stk_err  <= |s_flt;
        end
    end
endmodule

// File: rtl/mem_fault_guard_chk.sv
// Temporal checks on the fault detector's ports, bound to the top.
module mem_fault_guard_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PC_W     = 24,
    parameter int unsigned DATA_LO  = 32'h0040,
    parameter int unsigned DATA_HI  = 32'h27FF,
    parameter int unsigned PROG_HI  = 32'h007FFF,
    parameter int unsigned VEC_LO   = 32'h000004,
    parameter int unsigned VEC_HI   = 32'h00007F,
    parameter int unsigned SP_FLOOR = 32'h0800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dacc_vld,
    input logic [ADDR_W-1:0] dacc_addr,
    input logic              dacc_word,
    input logic              pc_vld,
    input logic [PC_W-1:0]   pc_addr,
    input logic              sp_vld,
    input logic [ADDR_W-1:0] sp_val,
    input logic              addr_err,
    input logic              stk_err
);
    localparam logic [ADDR_W-1:0] DLO = DATA_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DHI = DATA_HI[ADDR_W-1:0];
    localparam logic [PC_W-1:0]   PHI = PROG_HI[PC_W-1:0];
    localparam logic [PC_W-1:0]   VLO = VEC_LO[PC_W-1:0];
    localparam logic [PC_W-1:0]   VHI = VEC_HI[PC_W-1:0];
    localparam logic [ADDR_W-1:0] FLR = SP_FLOOR[ADDR_W-1:0];

    // R2
    word_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc_vld && dacc_word && dacc_addr[0]) |=> addr_err);

    // R3
    byte_odd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc_vld && !dacc_word && dacc_addr >= DLO && dacc_addr <= DHI && !pc_vld)
        |=> !addr_err);

    // R5
    prog_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_vld && pc_addr > PHI) |=> addr_err);

    // R6
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_vld && pc_addr >= VLO && pc_addr <= VHI) |=> addr_err);

    // R8
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_vld && sp_val < FLR) |=> stk_err);

    // R10
    quiet_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dacc_vld && !pc_vld) |=> !addr_err);

    // R10
    quiet_stk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_vld |=> !stk_err);
endmodule

bind mem_fault_guard mem_fault_guard_chk #(
    .ADDR_W  (ADDR_W),
    .PC_W    (PC_W),
    .DATA_LO (DATA_LO),
    .DATA_HI (DATA_HI),
    .PROG_HI (PROG_HI),
    .VEC_LO  (VEC_LO),
    .VEC_HI  (VEC_HI),
    .SP_FLOOR(SP_FLOOR)
) u_fault_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dacc_vld (dacc_vld),
    .dacc_addr(dacc_addr),
    .dacc_word(dacc_word),
    .pc_vld   (pc_vld),
    .pc_addr  (pc_addr),
    .sp_vld   (sp_vld),
    .sp_val   (sp_val),
    .addr_err (addr_err),
    .stk_err  (stk_err)
);

// File: tb/test_mem_fault_guard.sv
module test_mem_fault_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int PW = 24;
    localparam logic [AW-1:0] DLO = 16'h0040;
    localparam logic [AW-1:0] DHI = 16'h27FF;
    localparam logic [PW-1:0] PHI = 24'h007FFF;
    localparam logic [PW-1:0] VLO = 24'h000004;
    localparam logic [PW-1:0] VHI = 24'h00007F;
    localparam logic [AW-1:0] FLR = 16'h0800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dacc_vld = 0, dacc_word = 0, pc_vld = 0, sp_vld = 0, lim_wr = 0;
    logic [AW-1:0] dacc_addr = '0, sp_val = '0, lim_wdata = '0;
    logic [PW-1:0] pc_addr = '0;
    logic addr_err, stk_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [AW-1:0] lim_m = '1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_fault_guard i_mem_fault_guard (
        .clk(clk), .rst_n(rst_n),
        .dacc_vld(dacc_vld), .dacc_addr(dacc_addr), .dacc_word(dacc_word),
        .pc_vld(pc_vld), .pc_addr(pc_addr),
        .sp_vld(sp_vld), .sp_val(sp_val),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata),
        .addr_err(addr_err), .stk_err(stk_err)
    );

    function automatic string addr_tag(logic dv, logic [AW-1:0] da, logic dw,
                                       logic pv, logic [PW-1:0] pa);
        if (dv && dw && da[0]) return "R2";
        if (dv && (da < DLO || da > DHI)) return "R4";
        if (pv && pa > PHI) return "R5";
        if (pv && pa >= VLO && pa <= VHI) return "R6";
        if (dv && !dw) return "R3";
        return "R10";
    endfunction

    function automatic string stk_tag(logic sv, logic [AW-1:0] sa, logic [AW-1:0] lim);
        if (sv && sa > lim) return "R7";
        if (sv && sa < FLR) return "R8";
        return "R10";
    endfunction

    function automatic logic exp_addr(logic dv, logic [AW-1:0] da, logic dw,
                                      logic pv, logic [PW-1:0] pa);
        return (dv && ((dw && da[0]) || da < DLO || da > DHI)) ||
               (pv && (pa > PHI || (pa >= VLO && pa <= VHI)));
    endfunction

    function automatic logic exp_stk(logic sv, logic [AW-1:0] sa, logic [AW-1:0] lim);
        return sv && (sa > lim || sa < FLR);
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Apply one vector at a falling edge and check it one edge later.
    task automatic apply(logic dv, logic [AW-1:0] da, logic dw,
                         logic pv, logic [PW-1:0] pa,
                         logic sv, logic [AW-1:0] sa,
                         logic lw, logic [AW-1:0] ld, string tag);
        logic ea, es;
        string ta, ts;
        dacc_vld = dv; dacc_addr = da; dacc_word = dw;
        pc_vld = pv; pc_addr = pa;
        sp_vld = sv; sp_val = sa;
        lim_wr = lw; lim_wdata = ld;
        ea = exp_addr(dv, da, dw, pv, pa);
        es = exp_stk(sv, sa, lim_m);
        ta = (tag != "") ? tag : addr_tag(dv, da, dw, pv, pa);
        ts = (tag != "") ? tag : stk_tag(sv, sa, lim_m);
        if (lw) lim_m = ld;   // R11: new limit applies from the next cycle
        @(negedge clk);
        check(ta, addr_err, ea, "addr_err");
        check(ts, stk_err, es, "stk_err");
    endtask

    task automatic idle();
        apply(0, '0, 0, 0, '0, 0, '0, 0, '0, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: faulty stimulus during reset must not reach the outputs
        dacc_vld = 1; dacc_word = 1; dacc_addr = 16'h0101;
        pc_vld = 1; pc_addr = 24'h000010; sp_vld = 1; sp_val = 16'h0001;
        repeat (3) begin
            @(negedge clk);
            check("R1", addr_err, 1'b0, "addr_err in reset");
            check("R1", stk_err, 1'b0, "stk_err in reset");
        end
        dacc_vld = 0; pc_vld = 0; sp_vld = 0;
        rst_n = 1;
        // R1: limit at maximum after reset
        apply(0, '0, 0, 0, '0, 1, 16'hFFFF, 0, '0, "R1");
        // R2: odd word access
        apply(1, 16'h0101, 1, 0, '0, 0, '0, 0, '0, "R2");
        // R10: pulse drops after one cycle
        idle();
        // R3: odd byte access inside window, and at upper bound
        apply(1, 16'h0101, 0, 0, '0, 0, '0, 0, '0, "R3");
        apply(1, DHI, 0, 0, '0, 0, '0, 0, '0, "R3");
        // R4: window bounds and one past them
        apply(1, DLO, 1, 0, '0, 0, '0, 0, '0, "R4");
        apply(1, DLO - 16'd2, 1, 0, '0, 0, '0, 0, '0, "R4");
        apply(1, DHI + 16'd1, 0, 0, '0, 0, '0, 0, '0, "R4");
        // R5: program top and one past
        apply(0, '0, 0, 1, PHI, 0, '0, 0, '0, "R5");
        apply(0, '0, 0, 1, PHI + 24'd1, 0, '0, 0, '0, "R5");
        // R6: vector area edges
        apply(0, '0, 0, 1, VLO - 24'd1, 0, '0, 0, '0, "R6");
        apply(0, '0, 0, 1, VLO, 0, '0, 0, '0, "R6");
        apply(0, '0, 0, 1, VHI, 0, '0, 0, '0, "R6");
        apply(0, '0, 0, 1, VHI + 24'd1, 0, '0, 0, '0, "R6");
        // R8: floor edge
        apply(0, '0, 0, 0, '0, 1, FLR, 0, '0, "R8");
        apply(0, '0, 0, 0, '0, 1, FLR - 16'd1, 0, '0, "R8");
        // R11: write limit 0x1000 while SP=0x1800 -> old limit, no fault
        apply(0, '0, 0, 0, '0, 1, 16'h1800, 1, 16'h1000, "R11");
        apply(0, '0, 0, 0, '0, 1, 16'h1800, 0, '0, "R11");
        // R7: equal to limit is legal, one above faults
        apply(0, '0, 0, 0, '0, 1, 16'h1000, 0, '0, "R7");
        apply(0, '0, 0, 0, '0, 1, 16'h1001, 0, '0, "R7");
        // R9: both faults in one cycle
        apply(1, 16'h0203, 1, 0, '0, 1, 16'h0004, 0, '0, "R9");
        // R10: faulty values with strobes low
        apply(0, 16'h0003, 1, 0, 24'hFFFFFF, 0, 16'h0000, 0, '0, "R10");
        // Random phase with biased values
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] da, sa, ld;
            logic [PW-1:0] pa;
            int sel;
            sel = $urandom_range(0, 3);
            case (sel)
                0: da = DLO + 16'($urandom_range(0, 3)) - 16'd2;
                1: da = DHI + 16'($urandom_range(0, 3)) - 16'd2;
                default: da = 16'($urandom);
            endcase
            sel = $urandom_range(0, 4);
            case (sel)
                0: pa = VLO + 24'($urandom_range(0, 2)) - 24'd1;
                1: pa = VHI + 24'($urandom_range(0, 2)) - 24'd1;
                2: pa = PHI + 24'($urandom_range(0, 2)) - 24'd1;
                3: pa = 24'($urandom_range(0, 32'h9FFF));
                default: pa = 24'($urandom);
            endcase
            sel = $urandom_range(0, 3);
            case (sel)
                0: sa = FLR + 16'($urandom_range(0, 2)) - 16'd1;
                1: sa = lim_m + 16'($urandom_range(0, 2)) - 16'd1;
                default: sa = 16'($urandom);
            endcase
            ld = 16'h0800 + 16'($urandom_range(0, 32'h77FF));
            apply(1'($urandom), da, 1'($urandom), 1'($urandom), pa,
                  1'($urandom), sa, ($urandom_range(0, 7) == 0), ld, "");
        end
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule